// File: doc/BRIEF.md
# Tunable Low-Pass Filter Shadow Register Manager

This block sits between the control logic of a receiver and a generic SPI register master that serves a tunable low-pass filter device. It keeps local copies of the device's mode register (address 1), band register (address 2) and fine-tune register (address 3). It also accepts single-field set commands. For each command it checks the value against that field's limit and merges it into the right shadow copy. A full-register write goes to the SPI master only when the merged contents differ from what is already held.

After reset the block runs a detection sequence on its own. It reads the identification register at address 0. If the value matches, it loads the three shadow copies from the device. It then turns on the register-override mode, which sets bits 1 and 4 of the mode register. Only after that does it report the device as present. A wrong identification value, or a read error at any point in the sequence, leaves the block in an absent state, and in that state it rejects every command.

A request on the SPI side is held stable on `req_*` until the master returns a one-cycle `rsp_valid_i`. Reads return their data on `rsp_data_i`.

Top module: `lpf_shadow_ctrl`

## Requirements
- R1: Out of reset, `busy_o` is high, `present_o` is low, and the first request is a read (`req_write_o`=0) of address 0.
- R2: The device is present only when the address-0 read returns the identification value 24'h114080. Otherwise `present_o` stays low, `busy_o` falls, and no further request is made. `present_o` never falls without reset.
- R3: A response with `rsp_err_i` high to any detection read leaves the device absent.
- R4: When the identification matches, addresses 1, 2 and 3 are read in that order into the shadows. If mode bits 1 and 4 are not both set, address 1 is then written with both bits set. `present_o` rises in the cycle after the last response of this sequence.
- R5: Band fields (field code, bit position, limit): op-amp bias 0, bits 1:0, 3; driver bias 1, bits 3:2, 3; gain 2, bit 4, 1; bypass 3, bit 5, 1; coarse bandwidth 4, bits 9:6, 8. A change writes the whole merged register to address 2 and leaves the other bits unchanged.
- R6: A value above its field's limit, or field code 7, is ignored: no request is made and the shadow copy does not change.
- R7: A command that leaves the target register unchanged makes no request.
- R8: Fine bandwidth (field code 5) replaces all of address 3 and is accepted for values 0 through 10 only.
- R9: Override (field code 6) with value 1 sets mode bits 1 and 4, and value 0 clears both. It writes address 1 only when this changes the register. Values above 1 are ignored.
- R10: Commands are taken only while `busy_o` is low. `busy_o` is high from the cycle after an accepted write command until the cycle after its response, and a command presented while busy is dropped.
- R11: While `req_valid_o` is high and no response has arrived, the request's address, data and direction stay stable.
- R12: While absent, every command is rejected and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Field command strobe |
| cmd_field_i | input | 3 | Field code |
| cmd_value_i | input | VAL_W | Field value |
| req_valid_o | output | 1 | Request pending toward the SPI master |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_addr_o | output | ADDR_W | Device register address |
| req_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | Request completed (one cycle) |
| rsp_err_i | input | 1 | Completed request failed |
| rsp_data_i | input | DATA_W | Read data |
| present_o | output | 1 | Device detected and set up |
| busy_o | output | 1 | Detection or write in progress |

## Verification
The assertions check the per-cycle rules on every clock: request stability while unanswered, busy covering every pending request, present never falling, and no request following an illegal, unchanged or absent-state command. Field layout, merge results that keep the neighbouring bits, the order of the detection reads, the conditional override write, and the dropping of commands while busy can only be shown by the bench's scenarios, whose behavioural device model checks every request's address and data.

// File: rtl/lpf_shadow_pkg.sv
package lpf_shadow_pkg;

  typedef enum logic [2:0] {
    FLD_OPAMP    = 3'd0,
    FLD_DRIVER   = 3'd1,
    FLD_GAIN     = 3'd2,
    FLD_BYPASS   = 3'd3,
    FLD_COARSE   = 3'd4,
    FLD_FINE     = 3'd5,
    FLD_OVERRIDE = 3'd6,
    FLD_NONE     = 3'd7
  } field_e;

  typedef enum logic [2:0] {
    ST_RD_ID,
    ST_RD_MODE,
    ST_RD_BAND,
    ST_RD_FINE,
    ST_WR_WAIT,
    ST_IDLE,
    ST_ABSENT
  } state_e;

  localparam int unsigned BAND_FIELDS = 5;
  localparam int unsigned BAND_LSB [BAND_FIELDS] = '{0, 2, 4, 5, 6};
  localparam int unsigned BAND_WID [BAND_FIELDS] = '{2, 2, 1, 1, 4};
  localparam int unsigned BAND_MAX [BAND_FIELDS] = '{3, 3, 1, 1, 8};

  localparam int unsigned FINE_MAX  = 10;
  localparam int unsigned OVR_BIT_A = 1;
  localparam int unsigned OVR_BIT_B = 4;

  localparam int unsigned REG_ID   = 0;
  localparam int unsigned REG_MODE = 1;
  localparam int unsigned REG_BAND = 2;
  localparam int unsigned REG_FINE = 3;

endpackage

// File: rtl/lpf_field_merge.sv
module lpf_field_merge
  import lpf_shadow_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned VAL_W  = 4
) (
  input  field_e             field_i,
  input  logic [VAL_W-1:0]   value_i,
  input  logic [DATA_W-1:0]  mode_i,
  input  logic [DATA_W-1:0]  band_i,
  input  logic [DATA_W-1:0]  fine_i,
  output logic               legal_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  next_o,
  output logic               changed_o
);

  localparam logic [DATA_W-1:0] OVR_MASK =
    (DATA_W'(1) << OVR_BIT_A) | (DATA_W'(1) << OVR_BIT_B);

  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] fval;

  always_comb begin
    legal_o = 1'b0;
    addr_o  = ADDR_W'(REG_BAND);
    next_o  = band_i;
    cur     = band_i;
    fmask   = '0;
    fval    = '0;
    // band register fields, one descriptor per field code
    for (int k = 0; k < BAND_FIELDS; k++) begin
      if (field_i == field_e'(3'(k))) begin
        fmask   = ((DATA_W'(1) << BAND_WID[k]) - DATA_W'(1)) << BAND_LSB[k];
        fval    = (DATA_W'(value_i) << BAND_LSB[k]) & fmask;
        legal_o = 32'(value_i) <= BAND_MAX[k];
        next_o  = (band_i & ~fmask) | fval;
      end
    end
    case (field_i)
      FLD_FINE: begin
        addr_o  = ADDR_W'(REG_FINE);
        cur     = fine_i;
        legal_o = 32'(value_i) <= FINE_MAX;
        next_o  = DATA_W'(value_i);
      end
      FLD_OVERRIDE: begin
        addr_o  = ADDR_W'(REG_MODE);
        cur     = mode_i;
        legal_o = 32'(value_i) <= 1;
        next_o  = value_i[0] ? (mode_i | OVR_MASK) : (mode_i & ~OVR_MASK);
      end
      FLD_NONE: legal_o = 1'b0;
      default: ;
    endcase
    changed_o = next_o != cur;
  end

endmodule

// File: rtl/lpf_ctrl_fsm.sv
module lpf_ctrl_fsm
  import lpf_shadow_pkg::*;
#(
  parameter int unsigned        DATA_W   = 24,
  parameter int unsigned        ADDR_W   = 2,
  parameter logic [DATA_W-1:0]  ID_VALUE = 24'h114080
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic               legal_i,
  input  logic               changed_i,
  input  logic [ADDR_W-1:0]  tgt_addr_i,
  input  logic [DATA_W-1:0]  next_i,
  input  logic               rsp_valid_i,
  input  logic               rsp_err_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output logic [DATA_W-1:0]  mode_o,
  output logic [DATA_W-1:0]  band_o,
  output logic [DATA_W-1:0]  fine_o,
  output logic               req_valid_o,
  output logic               req_write_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [DATA_W-1:0]  req_wdata_o,
  output logic               present_o,
  output logic               busy_o
);

  localparam logic [DATA_W-1:0] OVR_MASK =
    (DATA_W'(1) << OVR_BIT_A) | (DATA_W'(1) << OVR_BIT_B);

  state_e             state_q;
  logic [DATA_W-1:0]  mode_q, band_q, fine_q, wdata_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               write_q, present_q;
  logic               rsp_ok;

  assign rsp_ok = rsp_valid_i && !rsp_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RD_ID;
      mode_q    <= '0;
      band_q    <= '0;
      fine_q    <= '0;
      wdata_q   <= '0;
      addr_q    <= ADDR_W'(REG_ID);
      write_q   <= 1'b0;
      present_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RD_ID: if (rsp_valid_i) begin
          if (rsp_ok && rsp_data_i == ID_VALUE) begin
            state_q <= ST_RD_MODE;
            addr_q  <= ADDR_W'(REG_MODE);
          end else state_q <= ST_ABSENT;
        end
        ST_RD_MODE: if (rsp_valid_i) begin
          if (rsp_ok) begin
            mode_q  <= rsp_data_i;
            addr_q  <= ADDR_W'(REG_BAND);
            state_q <= ST_RD_BAND;
          end else state_q <= ST_ABSENT;
        end
        ST_RD_BAND: if (rsp_valid_i) begin
          if (rsp_ok) begin
            band_q  <= rsp_data_i;
            addr_q  <= ADDR_W'(REG_FINE);
            state_q <= ST_RD_FINE;
          end else state_q <= ST_ABSENT;
        end
        ST_RD_FINE: if (rsp_valid_i) begin
          if (rsp_ok) begin
            fine_q <= rsp_data_i;
            // enable register override unless already on
            if ((mode_q & OVR_MASK) != OVR_MASK) begin
              mode_q  <= mode_q | OVR_MASK;
              wdata_q <= mode_q | OVR_MASK;
              addr_q  <= ADDR_W'(REG_MODE);
              write_q <= 1'b1;
              state_q <= ST_WR_WAIT;
            end else begin
              state_q   <= ST_IDLE;
              present_q <= 1'b1;
            end
          end else state_q <= ST_ABSENT;
        end
        ST_IDLE: if (cmd_valid_i && legal_i && changed_i) begin
          if (tgt_addr_i == ADDR_W'(REG_MODE))      mode_q <= next_i;
          else if (tgt_addr_i == ADDR_W'(REG_FINE)) fine_q <= next_i;
          else                                      band_q <= next_i;
          wdata_q <= next_i;
          addr_q  <= tgt_addr_i;
          write_q <= 1'b1;
          state_q <= ST_WR_WAIT;
        end
        ST_WR_WAIT: if (rsp_valid_i) begin
          state_q   <= ST_IDLE;
          present_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_RD_ID)   || (state_q == ST_RD_MODE) ||
                       (state_q == ST_RD_BAND) || (state_q == ST_RD_FINE) ||
                       (state_q == ST_WR_WAIT);
  assign req_write_o = write_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_ABSENT);
  assign present_o   = present_q;
  assign mode_o      = mode_q;
  assign band_o      = band_q;
  assign fine_o      = fine_q;

  // R11
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !rsp_valid_i |=> req_valid_o && $stable(req_addr_o) &&
    $stable(req_wdata_o) && $stable(req_write_o));

  // R10
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy_o);

  // R2
  present_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_o |=> present_o);

  // R6
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && cmd_valid_i && !legal_i |=> !req_valid_o);

  // R7
  same_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && cmd_valid_i && !changed_i |=> !req_valid_o);

  // R12
  absent_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ABSENT) |=> !req_valid_o && !present_o);

endmodule

// File: rtl/lpf_shadow_ctrl.sv
module lpf_shadow_ctrl
  import lpf_shadow_pkg::*;
#(
  parameter int unsigned        DATA_W   = 24,
  parameter int unsigned        ADDR_W   = 2,
  parameter int unsigned        VAL_W    = 4,
  parameter logic [DATA_W-1:0]  ID_VALUE = 24'h114080
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_field_i,
  input  logic [VAL_W-1:0]   cmd_value_i,
  output logic               req_valid_o,
  output logic               req_write_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [DATA_W-1:0]  req_wdata_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_err_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output logic               present_o,
  output logic               busy_o
);

  logic [DATA_W-1:0] mode_s, band_s, fine_s, next_s;
  logic [ADDR_W-1:0] tgt_s;
  logic              legal_s, changed_s;

  lpf_field_merge #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .VAL_W  (VAL_W)
  ) u_merge (
    .field_i   (field_e'(cmd_field_i)),
    .value_i   (cmd_value_i),
    .mode_i    (mode_s),
    .band_i    (band_s),
    .fine_i    (fine_s),
    .legal_o   (legal_s),
    .addr_o    (tgt_s),
    .next_o    (next_s),
    .changed_o (changed_s)
  );

  lpf_ctrl_fsm #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ID_VALUE (ID_VALUE)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .legal_i     (legal_s),
    .changed_i   (changed_s),
    .tgt_addr_i  (tgt_s),
    .next_i      (next_s),
    .rsp_valid_i (rsp_valid_i),
    .rsp_err_i   (rsp_err_i),
    .rsp_data_i  (rsp_data_i),
    .mode_o      (mode_s),
    .band_o      (band_s),
    .fine_o      (fine_s),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .present_o   (present_o),
    .busy_o      (busy_o)
  );

endmodule

// File: tb/lpf_shadow_ctrl_bench.sv
module lpf_shadow_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int ID_OK      = 32'h114080;
  localparam int OVR        = 32'h12;

  typedef struct {
    bit    wr;
    int    addr;
    int    data;
    string tag;
  } exp_t;

  logic        clk, rst_ni;
  logic        cmd_valid_i;
  logic [2:0]  cmd_field_i;
  logic [3:0]  cmd_value_i;
  logic        req_valid_o, req_write_o;
  logic [1:0]  req_addr_o;
  logic [23:0] req_wdata_o;
  logic        rsp_valid_i, rsp_err_i;
  logic [23:0] rsp_data_i;
  logic        present_o, busy_o;

  exp_t q[$];
  int   dev [4];
  int   m_mode, m_band, m_fine;
  bit   scen_present, init_done, in_rst, err_en;
  int   err_addr;
  int   errs, checks;

  lpf_shadow_ctrl u_lpf_shadow_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_field_i (cmd_field_i),
    .cmd_value_i (cmd_value_i),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_err_i   (rsp_err_i),
    .rsp_data_i  (rsp_data_i),
    .present_o   (present_o),
    .busy_o      (busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural device: answers each request after LAT cycles
  initial begin
    int a; bit w; int d;
    rsp_valid_i = 1'b0; rsp_err_i = 1'b0; rsp_data_i = '0;
    forever begin
      @(negedge clk);
      if (rst_ni && !in_rst && req_valid_o) begin
        a = int'(req_addr_o); w = req_write_o; d = int'(req_wdata_o);
        if (q.size() != 0) begin
          check(w == q[0].wr, q[0].tag, int'(w), int'(q[0].wr));
          check(a == q[0].addr, q[0].tag, a, q[0].addr);
          if (w) check(d == q[0].data, q[0].tag, d, q[0].data);
        end
        for (int i = 0; i < LAT; i++) begin
          @(negedge clk);
          check(req_valid_o && int'(req_addr_o) == a && int'(req_wdata_o) == d &&
                req_write_o == w, "R11", int'(req_wdata_o), d);
        end
        rsp_valid_i = 1'b1;
        rsp_err_i   = err_en && !w && a == err_addr;
        rsp_data_i  = dev[a][23:0];
        if (w) dev[a] = d;
        @(posedge clk);
        if (q.size() != 0) void'(q.pop_front());
        if (q.size() == 0) init_done = 1'b1;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        rsp_err_i   = 1'b0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!in_rst) begin
      check(busy_o == (q.size() != 0), "R10", int'(busy_o), int'(q.size() != 0));
      check(present_o == (scen_present && init_done), "R2", int'(present_o),
            int'(scen_present && init_done));
      check(!req_valid_o || q.size() != 0, "R6", int'(req_valid_o), 0);
    end
  end

  task automatic model(input int f, input int v, output bit wr, output int addr,
                       output int nv);
    int lsb, wid, mx, mask, cur; bit legal;
    legal = 0; addr = 2; nv = m_band; cur = m_band;
    if (f <= 4) begin
      case (f)
        0: begin lsb = 0; wid = 2; mx = 3; end
        1: begin lsb = 2; wid = 2; mx = 3; end
        2: begin lsb = 4; wid = 1; mx = 1; end
        3: begin lsb = 5; wid = 1; mx = 1; end
        default: begin lsb = 6; wid = 4; mx = 8; end
      endcase
      mask  = ((1 << wid) - 1) << lsb;
      legal = v <= mx;
      nv    = (m_band & ~mask) | ((v << lsb) & mask);
    end else if (f == 5) begin
      addr = 3; cur = m_fine; legal = v <= 10; nv = v;
    end else if (f == 6) begin
      addr = 1; cur = m_mode; legal = v <= 1;
      nv = (v == 1) ? (m_mode | OVR) : (m_mode & ~OVR);
    end
    wr = scen_present && legal && nv != cur;
  endtask

  task automatic commit(int addr, int nv, string tag);
    q.push_back('{1'b1, addr, nv, tag});
    if (addr == 1) m_mode = nv;
    else if (addr == 2) m_band = nv;
    else m_fine = nv;
  endtask

  task automatic send(int f, int v, string tag);
    bit wr; int addr, nv;
    while (busy_o) @(negedge clk);
    model(f, v, wr, addr, nv);
    cmd_valid_i = 1'b1; cmd_field_i = f[2:0]; cmd_value_i = v[3:0];
    @(posedge clk);
    if (wr) commit(addr, nv, tag);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    check(req_valid_o == wr, tag, int'(req_valid_o), int'(wr));
    while (q.size() != 0) @(negedge clk);
  endtask

  // a second command offered while busy must be dropped
  task automatic send_busy(int f, int v, int f2, int v2, string tag);
    bit wr; int addr, nv;
    model(f, v, wr, addr, nv);
    cmd_valid_i = 1'b1; cmd_field_i = f[2:0]; cmd_value_i = v[3:0];
    @(posedge clk);
    if (wr) commit(addr, nv, tag);
    @(negedge clk);
    check(busy_o == 1'b1, tag, int'(busy_o), 1);
    cmd_field_i = f2[2:0]; cmd_value_i = v2[3:0];
    @(negedge clk);
    cmd_valid_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic start_scen(int id, int r1, int r2, int r3, bit en, int ea);
    bit ok;
    rst_ni = 1'b0; in_rst = 1'b1; q.delete(); init_done = 1'b0;
    dev[0] = id; dev[1] = r1; dev[2] = r2; dev[3] = r3;
    err_en = en; err_addr = ea;
    m_mode = r1; m_band = r2; m_fine = r3;
    q.push_back('{1'b0, 0, 0, "R1"});
    ok = (id == ID_OK) && !(en && ea == 0);
    for (int a = 1; a <= 3; a++) begin
      if (ok) begin
        q.push_back('{1'b0, a, 0, "R4"});
        if (en && ea == a) ok = 1'b0;
      end
    end
    if (ok && (r1 & OVR) != OVR) begin
      q.push_back('{1'b1, 1, r1 | OVR, "R4"});
      m_mode = r1 | OVR;
    end
    scen_present = ok;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    in_rst = 1'b0;
    check(busy_o && !present_o && req_valid_o && !req_write_o && req_addr_o == 2'd0,
          "R1", {busy_o, present_o, req_valid_o, req_write_o}, 4'b1010);
    while (!init_done) @(negedge clk);
  endtask

  initial begin
    errs = 0; checks = 0; in_rst = 1'b1; rst_ni = 1'b0;
    cmd_valid_i = 1'b0; cmd_field_i = '0; cmd_value_i = '0;
    scen_present = 1'b0; init_done = 1'b0; err_en = 1'b0; err_addr = 0;

    // present, override off at power-up
    start_scen(ID_OK, 32'h0, 32'h0A0125, 32'h5, 1'b0, 0);
    check(present_o == 1'b1, "R4", int'(present_o), 1);
    check(dev[1] == OVR, "R4", dev[1], OVR);
    send(0, 3, "R5");
    send(0, 3, "R7");
    send(0, 4, "R6");
    send(1, 2, "R5");
    send(2, 1, "R5");
    send(2, 2, "R6");
    send(3, 0, "R5");
    send(4, 8, "R5");
    send(4, 9, "R6");
    send(4, 0, "R5");
    send(5, 10, "R8");
    send(5, 11, "R8");
    send(5, 10, "R7");
    send(6, 0, "R9");
    send(6, 1, "R9");
    send(6, 2, "R9");
    send(7, 0, "R6");
    send_busy(0, 2, 0, 0, "R10");
    send(0, 0, "R10");
    check(dev[2] == m_band, "R5", dev[2], m_band);
    check(dev[3] == 10, "R8", dev[3], 10);

    // present, override already on
    start_scen(ID_OK, 32'h112, 32'h0, 32'h0, 1'b0, 0);
    check(present_o == 1'b1, "R4", int'(present_o), 1);
    send(6, 1, "R9");
    send(6, 0, "R9");
    check(dev[1] == 32'h100, "R9", dev[1], 32'h100);

    // wrong identification
    start_scen(32'h114081, 32'h0, 32'h0, 32'h0, 1'b0, 0);
    repeat (3) @(negedge clk);
    check(!present_o && !busy_o, "R2", {present_o, busy_o}, 0);
    send(0, 2, "R12");

    // read error on band register
    start_scen(ID_OK, 32'h0, 32'h0, 32'h0, 1'b1, 2);
    repeat (3) @(negedge clk);
    check(!present_o && !busy_o, "R3", {present_o, busy_o}, 0);
    send(5, 3, "R12");

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule